// File: doc/BRIEF.md
# T1 Receive Payload Demapper

This block moves the payload of a received T1 line onto a 32-slot, 2.048 Mb/s serial backplane. The T1 side delivers one bit per strobe. An external aligner flags the framing bit of every 193-bit frame; a frame is that framing bit followed by 24 eight-bit channels. The block stores each received frame and replays the most recently completed one onto the backplane. It also gives a per-bit drive enable, so that the bus is driven only in the slots that carry data.

Both sides run from a single system clock and advance on single-cycle strobes. The backplane frame start is marked by a frame pulse given together with the strobe of its first bit. Received frames go into a two-bank store, and the banks swap when a frame marker closes a full frame. A frame that is cut short by an early marker is thrown away. An optional extra slot carries the received framing bit.

Top module: `t1_bp_demap`

## Requirements
- R1: While reset is held, and after it until the first backplane strobe, `bp_oe` and `bp_data` are 0.
- R2: Until a full frame has been received (one marker, 192 payload bits, then a closing marker), `bp_oe` stays 0 in every slot.
- R3: Received channel k (k = 1..24, in order of arrival after the framing bit) appears in backplane slot k-1. Slot n covers bit positions 8n..8n+7, and position 0 is the bit strobed with `bp_frame_pulse`.
- R4: Within a slot, the first backplane bit is bit 7. It carries the first received bit of the channel, and later bits follow in arrival order.
- R5: In backplane slots 24..30, `bp_oe` is 0 for all eight bits.
- R6: With `fbit_slot_en` = 1, slot 31 is driven (`bp_oe` = 1) for all eight bits. Its first bit carries the framing bit of the displayed frame and the other seven are 0.
- R7: With `fbit_slot_en` = 0, slot 31 is not driven.
- R8: The backplane shows the most recently completed frame. A frame that is only partly received has no effect on the output.
- R9: Whenever `bp_oe` is 0, `bp_data` is 0.
- R10: `bp_data` and `bp_oe` change only in the cycle after a backplane strobe and hold their values otherwise.
- R11: A frame closed by a marker before all 192 payload bits have arrived is dropped. The frame shown before stays on the backplane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock shared by both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| t1_bit_stb | input | 1 | One-cycle strobe per received T1 bit |
| t1_bit | input | 1 | Received T1 data bit |
| t1_frame_mark | input | 1 | Set with the strobe of the framing bit |
| bp_bit_stb | input | 1 | One-cycle strobe per backplane bit |
| bp_frame_pulse | input | 1 | Set with the strobe of backplane bit position 0 |
| fbit_slot_en | input | 1 | Drives the framing bit into slot 31 when set |
| bp_data | output | 1 | Backplane serial data |
| bp_oe | output | 1 | Backplane drive enable (low means high impedance) |

## Verification
The bench uses the default build: 24 channels of 8 bits on a 32-slot bus, with the framing-bit slot at 31 and that option included. With these values every slot class can be reached: payload, idle slots 24..30, and the framing-bit slot with its control bit both set and clear. A chosen order of complete, partial and cut-short frames drives the bank swap and the drop rule. Each of the four frames uses a different byte pattern and framing bit, so a wrong bank, channel or bit order shows up as a data mismatch.

// File: rtl/t1bp_pkg.sv
package t1bp_pkg;

   typedef enum logic [1:0] {
      SK_IDLE    = 2'd0,
      SK_PAYLOAD = 2'd1,
      SK_FBIT    = 2'd2
   } slot_kind_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/t1bp_wr_ctl.sv
module t1bp_wr_ctl #(
   parameter int N_CH = 24,
   parameter int BW   = 8,
   localparam int TOTAL = N_CH * BW,
   localparam int CNT_W = $clog2(TOTAL + 1),
   localparam int CH_W  = $clog2(N_CH),
   localparam int LG    = $clog2(BW)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bit_stb,
   input  logic            bit_in,
   input  logic            frm_mark,
   output logic            wr_en,
   output logic            wr_bank,
   output logic [CH_W-1:0] wr_ch,
   output logic [LG-1:0]   wr_bit,
   output logic            wr_data,
   output logic            fb_we,
   output logic            fb_bank,
   output logic            done_bank,
   output logic            done_valid
);

   logic             started_q;
   logic             wbank_q;
   logic [CNT_W-1:0] cnt_q;
   logic             full;

   assign full = (cnt_q == CNT_W'(TOTAL));

   always_comb begin
      wr_en   = bit_stb && !frm_mark && started_q && !full;
      wr_bank = wbank_q;
      wr_ch   = CH_W'(cnt_q >> LG);
      wr_bit  = LG'(BW - 1) - cnt_q[LG-1:0];
      wr_data = bit_in;
      fb_we   = bit_stb && frm_mark;
      fb_bank = (started_q && full) ? ~wbank_q : wbank_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         started_q  <= 1'b0;
         wbank_q    <= 1'b0;
         cnt_q      <= '0;
         done_bank  <= 1'b0;
         done_valid <= 1'b0;
      end else if (bit_stb) begin
         if (frm_mark) begin
            started_q <= 1'b1;
            cnt_q     <= '0;
            if (started_q && full) begin
               done_bank  <= wbank_q;
               done_valid <= 1'b1;
               wbank_q    <= ~wbank_q;
            end
         end else if (wr_en) begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

endmodule

// File: rtl/t1bp_bank_store.sv
module t1bp_bank_store #(
   parameter int N_CH     = 24,
   parameter int BW       = 8,
   parameter bit FBIT_OPT = 1'b1,
   localparam int CH_W = $clog2(N_CH),
   localparam int LG   = $clog2(BW)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic            wr_bank,
   input  logic [CH_W-1:0] wr_ch,
   input  logic [LG-1:0]   wr_bit,
   input  logic            wr_data,
   input  logic            fb_we,
   input  logic            fb_bank,
   input  logic            fb_data,
   input  logic            rd_bank,
   input  logic [CH_W-1:0] rd_ch,
   input  logic [LG-1:0]   rd_bit,
   output logic            rd_payload,
   output logic            rd_fbit
);

   logic [BW-1:0] mem_q [2][N_CH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < 2; b++) begin
            for (int c = 0; c < N_CH; c++) begin
               mem_q[b][c] <= '0;
            end
         end
      end else if (wr_en) begin
         mem_q[wr_bank][wr_ch][wr_bit] <= wr_data;
      end
   end

   assign rd_payload = mem_q[rd_bank][rd_ch][rd_bit];

   generate
      if (FBIT_OPT) begin : g_fbit_store
         logic [1:0] fb_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               fb_q <= '0;
            end else if (fb_we) begin
               fb_q[fb_bank] <= fb_data;
            end
         end
         assign rd_fbit = fb_q[rd_bank];
      end else begin : g_no_fbit_store
         assign rd_fbit = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/t1bp_rd_ctl.sv
module t1bp_rd_ctl
   import t1bp_pkg::*;
#(
   parameter int N_CH      = 24,
   parameter int BW        = 8,
   parameter int N_SLOT    = 32,
   parameter int FBIT_SLOT = 31,
   parameter bit FBIT_OPT  = 1'b1,
   localparam int CH_W   = $clog2(N_CH),
   localparam int LG     = $clog2(BW),
   localparam int POS_W  = $clog2(N_SLOT * BW),
   localparam int SLOT_W = POS_W - LG
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bit_stb,
   input  logic            frm_pulse,
   input  logic            fbit_en,
   input  logic            done_bank,
   input  logic            done_valid,
   input  logic            rd_payload,
   input  logic            rd_fbit,
   output logic            rd_bank,
   output logic [CH_W-1:0] rd_ch,
   output logic [LG-1:0]   rd_bit,
   output logic            bp_data,
   output logic            bp_oe
);

   logic [POS_W-1:0]  pos_q;
   logic              aligned_q;
   logic [POS_W-1:0]  nxt_pos;
   logic [SLOT_W-1:0] slot;
   logic              aligned_n;
   logic              is_fb_slot;
   slot_kind_e        kind;
   logic              oe_n;
   logic              dat_n;

   assign nxt_pos   = frm_pulse ? '0 : pos_q + POS_W'(1);
   assign slot      = nxt_pos[POS_W-1:LG];
   assign aligned_n = aligned_q | frm_pulse;

   generate
      if (FBIT_OPT) begin : g_fbit_decode
         assign is_fb_slot = (slot == SLOT_W'(FBIT_SLOT));
      end else begin : g_no_fbit_decode
         assign is_fb_slot = 1'b0;
      end
   endgenerate

   always_comb begin
      if (slot < SLOT_W'(N_CH)) begin
         kind = SK_PAYLOAD;
      end else if (is_fb_slot) begin
         kind = SK_FBIT;
      end else begin
         kind = SK_IDLE;
      end
   end

   assign rd_bank = done_bank;
   assign rd_ch   = (kind == SK_PAYLOAD) ? CH_W'(slot) : '0;
   assign rd_bit  = LG'(BW - 1) - nxt_pos[LG-1:0];

   always_comb begin
      oe_n  = 1'b0;
      dat_n = 1'b0;
      if (aligned_n && done_valid) begin
         unique case (kind)
            SK_PAYLOAD: begin
               oe_n  = 1'b1;
               dat_n = rd_payload;
            end
            SK_FBIT: begin
               if (fbit_en) begin
                  oe_n  = 1'b1;
                  dat_n = (rd_bit == LG'(BW - 1)) ? rd_fbit : 1'b0;
               end
            end
            default: begin
               oe_n  = 1'b0;
               dat_n = 1'b0;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q     <= '0;
         aligned_q <= 1'b0;
         bp_oe     <= 1'b0;
         bp_data   <= 1'b0;
      end else if (bit_stb) begin
         pos_q     <= nxt_pos;
         aligned_q <= aligned_n;
         bp_oe     <= oe_n;
         bp_data   <= dat_n;
      end
   end

endmodule

// File: rtl/t1_bp_demap.sv
module t1_bp_demap #(
   parameter int N_CH      = 24,
   parameter int BW        = 8,
   parameter int N_SLOT    = 32,
   parameter int FBIT_SLOT = 31,
   parameter bit FBIT_OPT  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic t1_bit_stb,
   input  logic t1_bit,
   input  logic t1_frame_mark,
   input  logic bp_bit_stb,
   input  logic bp_frame_pulse,
   input  logic fbit_slot_en,
   output logic bp_data,
   output logic bp_oe
);

   localparam int CH_W = $clog2(N_CH);
   localparam int LG   = $clog2(BW);

   generate
      if (!t1bp_pkg::is_pow2(BW)) begin : g_err_bw
         $error("t1_bp_demap: BW must be a power of two");
      end
      if (!t1bp_pkg::is_pow2(N_SLOT * BW)) begin : g_err_frame
         $error("t1_bp_demap: N_SLOT*BW must be a power of two");
      end
      if (N_CH < 2 || N_CH >= N_SLOT) begin : g_err_ch
         $error("t1_bp_demap: N_CH must lie in 2..N_SLOT-1");
      end
      if (FBIT_SLOT < N_CH || FBIT_SLOT >= N_SLOT) begin : g_err_fslot
         $error("t1_bp_demap: FBIT_SLOT must lie in N_CH..N_SLOT-1");
      end
   endgenerate

   logic            wr_en;
   logic            wr_bank;
   logic [CH_W-1:0] wr_ch;
   logic [LG-1:0]   wr_bit;
   logic            wr_data;
   logic            fb_we;
   logic            fb_bank;
   logic            done_bank;
   logic            done_valid;
   logic            rd_bank;
   logic [CH_W-1:0] rd_ch;
   logic [LG-1:0]   rd_bit;
   logic            rd_payload;
   logic            rd_fbit;

   t1bp_wr_ctl #(.N_CH(N_CH), .BW(BW)) u_wr (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_stb    (t1_bit_stb),
      .bit_in     (t1_bit),
      .frm_mark   (t1_frame_mark),
      .wr_en      (wr_en),
      .wr_bank    (wr_bank),
      .wr_ch      (wr_ch),
      .wr_bit     (wr_bit),
      .wr_data    (wr_data),
      .fb_we      (fb_we),
      .fb_bank    (fb_bank),
      .done_bank  (done_bank),
      .done_valid (done_valid)
   );

   t1bp_bank_store #(.N_CH(N_CH), .BW(BW), .FBIT_OPT(FBIT_OPT)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_bank    (wr_bank),
      .wr_ch      (wr_ch),
      .wr_bit     (wr_bit),
      .wr_data    (wr_data),
      .fb_we      (fb_we),
      .fb_bank    (fb_bank),
      .fb_data    (t1_bit),
      .rd_bank    (rd_bank),
      .rd_ch      (rd_ch),
      .rd_bit     (rd_bit),
      .rd_payload (rd_payload),
      .rd_fbit    (rd_fbit)
   );

   t1bp_rd_ctl #(
      .N_CH(N_CH), .BW(BW), .N_SLOT(N_SLOT),
      .FBIT_SLOT(FBIT_SLOT), .FBIT_OPT(FBIT_OPT)
   ) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_stb    (bp_bit_stb),
      .frm_pulse  (bp_frame_pulse),
      .fbit_en    (fbit_slot_en),
      .done_bank  (done_bank),
      .done_valid (done_valid),
      .rd_payload (rd_payload),
      .rd_fbit    (rd_fbit),
      .rd_bank    (rd_bank),
      .rd_ch      (rd_ch),
      .rd_bit     (rd_bit),
      .bp_data    (bp_data),
      .bp_oe      (bp_oe)
   );

endmodule

// File: rtl/t1_bp_demap_chk.sv
module t1_bp_demap_chk #(
   parameter int N_CH      = 24,
   parameter int BW        = 8,
   parameter int N_SLOT    = 32,
   parameter int FBIT_SLOT = 31
) (
   input logic clk,
   input logic rst_n,
   input logic t1_bit_stb,
   input logic t1_frame_mark,
   input logic bp_bit_stb,
   input logic bp_frame_pulse,
   input logic fbit_slot_en,
   input logic bp_data,
   input logic bp_oe
);

   localparam int LG     = $clog2(BW);
   localparam int POS_W  = $clog2(N_SLOT * BW);
   localparam int SLOT_W = POS_W - LG;

   logic [POS_W-1:0]  pos_q;
   logic              aligned_q;
   logic [1:0]        marks_q;
   logic [SLOT_W-1:0] slot;

   assign slot = pos_q[POS_W-1:LG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q     <= '0;
         aligned_q <= 1'b0;
         marks_q   <= '0;
      end else begin
         if (bp_bit_stb) begin
            aligned_q <= aligned_q | bp_frame_pulse;
            pos_q     <= bp_frame_pulse ? '0 : pos_q + POS_W'(1);
         end
         if (t1_bit_stb && t1_frame_mark && marks_q != 2'd2) begin
            marks_q <= marks_q + 2'd1;
         end
      end
   end

   assert_quiet_before_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (marks_q != 2'd2) |-> !bp_oe);

   assert_idle_slots_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (aligned_q && slot >= SLOT_W'(N_CH) && slot < SLOT_W'(FBIT_SLOT)) |-> !bp_oe);

   assert_fbit_slot_pad_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (aligned_q && slot == SLOT_W'(FBIT_SLOT) && pos_q[LG-1:0] != '0) |-> !bp_data);

   assert_fbit_slot_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (aligned_q && slot == SLOT_W'(FBIT_SLOT) && $past(bp_bit_stb) && !$past(fbit_slot_en))
      |-> !bp_oe);

   assert_no_data_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !bp_oe |-> !bp_data);

   assert_hold_between_strobes_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bp_bit_stb) |-> ($stable(bp_data) && $stable(bp_oe)));

endmodule

bind t1_bp_demap t1_bp_demap_chk #(
   .N_CH(N_CH), .BW(BW), .N_SLOT(N_SLOT), .FBIT_SLOT(FBIT_SLOT)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .t1_bit_stb     (t1_bit_stb),
   .t1_frame_mark  (t1_frame_mark),
   .bp_bit_stb     (bp_bit_stb),
   .bp_frame_pulse (bp_frame_pulse),
   .fbit_slot_en   (fbit_slot_en),
   .bp_data        (bp_data),
   .bp_oe          (bp_oe)
);

// File: tb/tb_t1_bp_demap.sv
module tb_t1_bp_demap;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic t1_stb = 1'b0, t1_d = 1'b0, t1_mark = 1'b0;
   logic bp_stb = 1'b0, bp_fp = 1'b0, fen = 1'b0;
   logic bp_data, bp_oe;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   t1_bp_demap dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .t1_bit_stb     (t1_stb),
      .t1_bit         (t1_d),
      .t1_frame_mark  (t1_mark),
      .bp_bit_stb     (bp_stb),
      .bp_frame_pulse (bp_fp),
      .fbit_slot_en   (fen),
      .bp_data        (bp_data),
      .bp_oe          (bp_oe)
   );

   function automatic logic [7:0] pat(input int seed, input int ch);
      return 8'((seed * 53 + ch * 29 + 7) ^ (seed * 3));
   endfunction

   task automatic chk(input logic act, input logic exp, input string req,
                      input string what, input int s, input int j);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s slot %0d bit %0d: actual %b expected %b",
                  req, what, s, j, act, exp);
      end
   endtask

   task automatic t1_bit(input logic d, input logic m);
      @(posedge clk);
      t1_stb  <= 1'b1;
      t1_d    <= d;
      t1_mark <= m;
      @(posedge clk);
      t1_stb  <= 1'b0;
      t1_mark <= 1'b0;
   endtask

   // framing bit, then nbits payload bits, channel by channel, first bit = byte MSB
   task automatic t1_frame(input int seed, input logic fb, input int nbits);
      int n = 0;
      t1_bit(fb, 1'b1);
      for (int c = 0; c < 24; c++) begin
         for (int b = 0; b < 8; b++) begin
            if (n < nbits) t1_bit(pat(seed, c)[7-b], 1'b0);
            n++;
         end
      end
   endtask

   // one backplane frame; shown = 0 means nothing may be driven (R2)
   task automatic bp_frame(input logic shown, input int seed, input logic fb);
      logic eo, ed, po, pd;
      string req;
      for (int s = 0; s < 32; s++) begin
         for (int j = 0; j < 8; j++) begin
            @(posedge clk);
            bp_stb <= 1'b1;
            bp_fp  <= (s == 0 && j == 0);
            @(posedge clk);
            bp_stb <= 1'b0;
            bp_fp  <= 1'b0;
            @(negedge clk);
            if (!shown) begin
               eo = 1'b0; ed = 1'b0; req = "R2";
            end else if (s < 24) begin
               eo = 1'b1; ed = pat(seed, s)[7-j]; req = "R3 R4 R8";
            end else if (s < 31) begin
               eo = 1'b0; ed = 1'b0; req = "R5 R9";
            end else if (fen) begin
               eo = 1'b1; ed = (j == 0) ? fb : 1'b0; req = "R6";
            end else begin
               eo = 1'b0; ed = 1'b0; req = "R7 R9";
            end
            chk(bp_oe, eo, req, "oe", s, j);
            chk(bp_data, ed, req, "data", s, j);
            po = bp_oe;
            pd = bp_data;
            @(posedge clk);
            @(negedge clk);
            chk(bp_oe, po, "R10", "oe hold", s, j);
            chk(bp_data, pd, "R10", "data hold", s, j);
         end
      end
   endtask

   task automatic test_reset;
      @(negedge clk);
      chk(bp_oe, 1'b0, "R1", "oe in reset", 0, 0);
      chk(bp_data, 1'b0, "R1", "data in reset", 0, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(bp_oe, 1'b0, "R1", "oe after reset", 0, 0);
      chk(bp_data, 1'b0, "R1", "data after reset", 0, 0);
   endtask

   task automatic test_before_first_frame;
      bp_frame(1'b0, 0, 1'b0);          // R2: nothing received
      t1_frame(11, 1'b1, 192);          // R2: full frame but not yet closed
      bp_frame(1'b0, 0, 1'b0);
   endtask

   task automatic test_payload_map;
      fen = 1'b0;
      t1_frame(22, 1'b0, 100);          // closes frame 11, frame 22 partial (R8)
      bp_frame(1'b1, 11, 1'b1);         // R3 R4 R5 R7
   endtask

   task automatic test_fbit_slot;
      fen = 1'b1;
      bp_frame(1'b1, 11, 1'b1);         // R6 with framing bit 1
   endtask

   task automatic test_short_frame_dropped;
      t1_frame(33, 1'b1, 192);          // cuts frame 22 short: R11
      bp_frame(1'b1, 11, 1'b1);         // frame 11 still shown
   endtask

   task automatic test_bank_alternation;
      t1_bit(1'b0, 1'b1);               // closes frame 33
      bp_frame(1'b1, 33, 1'b1);         // R8 R11
      t1_frame(44, 1'b0, 192);          // drops the empty frame, starts 44
      t1_bit(1'b1, 1'b1);               // closes frame 44
      bp_frame(1'b1, 44, 1'b0);         // R6 with framing bit 0, other bank
      fen = 1'b0;
      bp_frame(1'b1, 44, 1'b0);         // R7 again
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      test_reset();
      test_before_first_frame();
      test_payload_map();
      test_fbit_slot();
      test_short_frame_dropped();
      test_bank_alternation();
      repeat (4) @(posedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule